// File: doc/BRIEF.md
# Memory-Operand ALU with Status Flags

This block computes one of four byte operations on a memory operand and derives the six status flags for it. Exclusive-OR and compare take the accumulator as the first operand. Increment and decrement work on the memory operand alone. The result, the accumulator write-enable and the memory write-enable are combinational, so a datapath can use them in the same cycle. The new flag byte is captured in a flag register on the rising clock edge, but only when the load strobe is high.

The caller supplies the current flag byte because increment and decrement must carry its C bit forward unchanged. The P/V flag has a different meaning for each operation. For exclusive-OR it reports even parity. For compare it reports signed overflow. For increment and decrement it flags one exact operand value.

Top module: `memop_alu`

## Requirements
- R1: `op_sel` encodes 0 = XOR, 1 = compare, 2 = increment, 3 = decrement. XOR raises only `acc_we_o`. Compare raises neither write-enable. Increment and decrement raise only `mem_we_o`.
- R2: XOR drives `result_o` = accumulator XOR operand. S is result bit 7 and Z is set for a zero result. H, N and C are cleared.
- R3: For XOR, P/V is 1 when the result contains an even number of one bits.
- R4: Compare drives `result_o` = (accumulator − operand) mod 256. S and Z follow that difference, and N is set.
- R5: For compare, H is set when the low nibble of the accumulator is smaller than the low nibble of the operand. C is set when the accumulator is smaller than the operand, both taken as unsigned.
- R6: For compare, P/V is set when the signed difference lies outside −128..127.
- R7: Increment drives `result_o` = (operand + 1) mod 256. S and Z follow the result. H is set when the operand's low nibble is 0xF. P/V is set only when the operand is 0x7F. N is cleared.
- R8: Decrement drives `result_o` = (operand − 1) mod 256. S and Z follow the result. H is set when the operand's low nibble is 0x0. P/V is set only when the operand is 0x80. N is set.
- R9: Increment and decrement copy C from `flags_in` bit 0.
- R10: The flag byte holds S at bit 7, Z at bit 6, H at bit 4, P/V at bit 2, N at bit 1 and C at bit 0. Bits 5 and 3 read 0.
- R11: `flags_o` takes the new flag byte on a rising edge only when `flag_load` is 1. Otherwise it holds its value.
- R12: A synchronous `rst` clears `flags_o` to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 2 | Operation select |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Memory operand byte |
| flags_in | input | 8 | Current flag byte (bit 0 is C) |
| flag_load | input | 1 | Flag register load strobe |
| result_o | output | 8 | Operation result |
| acc_we_o | output | 1 | Accumulator write-enable |
| mem_we_o | output | 1 | Memory write-enable |
| flags_o | output | 8 | Registered flag byte |

## Verification
The only state in the block is the flag register. A wrong value there shows on `flags_o` one edge after the load that produced it. The same wrong value then persists through every cycle where the strobe is low, and the reference model compares it on each of those cycles. Errors in the result or the write-enables are combinational and show in the same cycle as the inputs. The stimulus focuses on the operand values where P/V and H switch meaning: 0x7F, 0x80, nibble edges and equal operands. It also drives C into increment and decrement both ways, so a lost carry is exposed at the next load.

// File: rtl/memop_alu_pkg.sv
package memop_alu_pkg;

    typedef enum logic [1:0] {
        OP_XOR = 2'd0,
        OP_CMP = 2'd1,
        OP_INC = 2'd2,
        OP_DEC = 2'd3
    } mop_e;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } stat_t;

    localparam int FLAG_W = 8;
    localparam int S_BIT  = 7;
    localparam int Z_BIT  = 6;
    localparam int H_BIT  = 4;
    localparam int PV_BIT = 2;
    localparam int N_BIT  = 1;
    localparam int C_BIT  = 0;

    function automatic logic [FLAG_W-1:0] pack_stat(input stat_t st);
        logic [FLAG_W-1:0] b;
        b         = '0;
        b[S_BIT]  = st.s;
        b[Z_BIT]  = st.z;
        b[H_BIT]  = st.h;
        b[PV_BIT] = st.pv;
        b[N_BIT]  = st.n;
        b[C_BIT]  = st.c;
        return b;
    endfunction

endpackage

// File: rtl/memop_logic_unit.sv
module memop_logic_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         even_o
);
    logic [W-1:0] x;
    logic [W:0]   par_chain;

    assign par_chain[0] = 1'b0;
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign x[i]             = a_i[i] ^ b_i[i];
            assign par_chain[i + 1] = par_chain[i] ^ x[i];
        end
    endgenerate

    assign res_o  = x;
    assign even_o = ~par_chain[W];

    // R3: a zero result has no one bits, so it must report even parity
    always_comb begin
        if (x == '0) begin
            a_r3_zero_even : assert (even_o);
        end
    end
endmodule

// File: rtl/memop_addsub.sv
module memop_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         nib_o,
    output logic         out_o,
    output logic         ovf_o
);
    localparam int LO_W = W / 2;
    localparam int HI_W = W - LO_W;

    logic [W-1:0]  bb;
    logic [LO_W:0] lo_sum;
    logic [HI_W:0] hi_sum;

    always_comb begin
        bb     = b_i ^ {W{sub_i}};
        lo_sum = {1'b0, a_i[LO_W-1:0]} + {1'b0, bb[LO_W-1:0]}
               + {{LO_W{1'b0}}, sub_i};
        hi_sum = {1'b0, a_i[W-1:LO_W]} + {1'b0, bb[W-1:LO_W]}
               + {{HI_W{1'b0}}, lo_sum[LO_W]};
        res_o  = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
        nib_o  = lo_sum[LO_W] ^ sub_i;
        out_o  = hi_sum[HI_W] ^ sub_i;
        ovf_o  = (a_i[W-1] == bb[W-1]) && (res_o[W-1] != a_i[W-1]);
    end

    // R5: on subtraction the outgoing borrow matches an unsigned magnitude test
    always_comb begin
        if (sub_i) begin
            a_r5_borrow_order : assert (out_o == (a_i < b_i));
        end
    end
endmodule

// File: rtl/memop_flag_reg.sv
module memop_flag_reg
    import memop_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  stat_t             stat_i,
    output logic [FLAG_W-1:0] flags_o
);
    typedef struct packed {
        stat_t st;
    } freg_t;

    freg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (load_i) begin
            reg_d.st = stat_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign flags_o = pack_stat(reg_q.st);

    // R11: without a strobe the stored byte must not move
    a_r11_hold : assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(flags_o));

    // R12: the first cycle after reset release shows a cleared byte
    a_r12_reset_clear : assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (flags_o == '0));
endmodule

// File: rtl/memop_alu.sv
module memop_alu
    import memop_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic              flag_load,
    output logic [DATA_W-1:0] result_o,
    output logic              acc_we_o,
    output logic              mem_we_o,
    output logic [FLAG_W-1:0] flags_o
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              acc_we;
        logic              mem_we;
        stat_t             st;
    } alu_out_t;

    mop_e              op;
    logic [DATA_W-1:0] x_res;
    logic              x_even;
    logic [DATA_W-1:0] as_a, as_b, as_res;
    logic              as_sub, as_nib, as_out, as_ovf;
    alu_out_t          alu_d;
    logic              unused_flag_bits;

    assign op               = mop_e'(op_sel);
    assign unused_flag_bits = ^{flags_in[FLAG_W-1:1]};

    // Compare subtracts operand from accumulator; inc/dec run the operand
    // through the same adder against a constant one.
    always_comb begin
        as_a   = (op == OP_CMP) ? acc_in : opnd_in;
        as_b   = (op == OP_CMP) ? opnd_in : {{(DATA_W-1){1'b0}}, 1'b1};
        as_sub = (op != OP_INC);
    end

    memop_logic_unit #(.W(DATA_W)) u_logic (
        .a_i    (acc_in),
        .b_i    (opnd_in),
        .res_o  (x_res),
        .even_o (x_even)
    );

    memop_addsub #(.W(DATA_W)) u_addsub (
        .a_i   (as_a),
        .b_i   (as_b),
        .sub_i (as_sub),
        .res_o (as_res),
        .nib_o (as_nib),
        .out_o (as_out),
        .ovf_o (as_ovf)
    );

    always_comb begin
        alu_d = '0;
        case (op)
            OP_XOR: begin
                alu_d.res    = x_res;
                alu_d.acc_we = 1'b1;
                alu_d.st.pv  = x_even;
            end
            OP_CMP: begin
                alu_d.res   = as_res;
                alu_d.st.h  = as_nib;
                alu_d.st.pv = as_ovf;
                alu_d.st.n  = 1'b1;
                alu_d.st.c  = as_out;
            end
            OP_INC: begin
                alu_d.res    = as_res;
                alu_d.mem_we = 1'b1;
                alu_d.st.h   = as_nib;
                alu_d.st.pv  = as_ovf;
                alu_d.st.c   = flags_in[C_BIT];
            end
            default: begin
                alu_d.res    = as_res;
                alu_d.mem_we = 1'b1;
                alu_d.st.h   = as_nib;
                alu_d.st.pv  = as_ovf;
                alu_d.st.n   = 1'b1;
                alu_d.st.c   = flags_in[C_BIT];
            end
        endcase
        alu_d.st.s = alu_d.res[DATA_W-1];
        alu_d.st.z = (alu_d.res == '0);
    end

    memop_flag_reg u_flags (
        .clk     (clk),
        .rst     (rst),
        .load_i  (flag_load),
        .stat_i  (alu_d.st),
        .flags_o (flags_o)
    );

    assign result_o = alu_d.res;
    assign acc_we_o = alu_d.acc_we;
    assign mem_we_o = alu_d.mem_we;

    // R1: at most one destination is written in any cycle
    always_comb begin
        a_r1_single_dest : assert (!(acc_we_o && mem_we_o));
    end

    // R1: compare never writes anything
    a_r1_cmp_silent : assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'd1) |-> (!acc_we_o && !mem_we_o));

    // R9: a loaded inc/dec leaves the incoming carry in the register
    a_r9_carry_kept : assert property (@(posedge clk) disable iff (rst)
        (flag_load && op_sel[1]) |=> (flags_o[0] == $past(flags_in[0])));

    // R10: unused flag positions stay clear after any update
    a_r10_gaps_clear : assert property (@(posedge clk) disable iff (rst)
        flag_load |=> (flags_o[5] == 1'b0 && flags_o[3] == 1'b0));
endmodule

// File: tb/sim_memop_alu.sv
module sim_memop_alu;
    logic       clk;
    logic       rst;
    logic [1:0] op_sel;
    logic [7:0] acc_in, opnd_in, flags_in;
    logic       flag_load;
    logic [7:0] result_o;
    logic       acc_we_o, mem_we_o;
    logic [7:0] flags_o;

    int    n_chk;
    int    n_bad;
    bit    done;
    int    m_flags;
    string m_tag;

    memop_alu u0 (
        .clk       (clk),
        .rst       (rst),
        .op_sel    (op_sel),
        .acc_in    (acc_in),
        .opnd_in   (opnd_in),
        .flags_in  (flags_in),
        .flag_load (flag_load),
        .result_o  (result_o),
        .acc_we_o  (acc_we_o),
        .mem_we_o  (mem_we_o),
        .flags_o   (flags_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", req, $time, act, exp);
        end
    endtask

    // Reference behaviour: returns {flags, acc_we, mem_we, result}
    function automatic int model(input int op, input int a, input int m, input int fin);
        int r, s, z, h, pv, n, c, aw, mw, ones, sa, sm, sd;
        h = 0; pv = 0; n = 0; c = 0; aw = 0; mw = 0;
        if (op == 0) begin                       // R2, R3
            r = a ^ m; aw = 1; ones = 0;
            for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
            pv = (ones % 2 == 0) ? 1 : 0;
        end else if (op == 1) begin              // R4, R5, R6
            r  = (a - m) & 255; n = 1;
            c  = (a < m) ? 1 : 0;
            h  = ((a % 16) < (m % 16)) ? 1 : 0;
            sa = (a > 127) ? a - 256 : a;
            sm = (m > 127) ? m - 256 : m;
            sd = sa - sm;
            pv = (sd < -128 || sd > 127) ? 1 : 0;
        end else if (op == 2) begin              // R7, R9
            r  = (m + 1) & 255; mw = 1;
            h  = ((m % 16) == 15) ? 1 : 0;
            pv = (m == 127) ? 1 : 0;
            c  = fin & 1;
        end else begin                           // R8, R9
            r  = (m + 255) & 255; mw = 1; n = 1;
            h  = ((m % 16) == 0) ? 1 : 0;
            pv = (m == 128) ? 1 : 0;
            c  = fin & 1;
        end
        s = (r >= 128) ? 1 : 0;
        z = (r == 0) ? 1 : 0;
        // R10 layout: S7 Z6 H4 PV2 N1 C0
        return ((s*128 + z*64 + h*16 + pv*4 + n*2 + c) << 16) + (aw << 9) + (mw << 8) + r;
    endfunction

    // Compare outputs, then apply new inputs and advance the flag model
    task automatic step(input bit r, input int op, input int a, input int m,
                        input int fin, input bit ld);
        int e;
        @(negedge clk);
        e = model(int'(op_sel), int'(acc_in), int'(opnd_in), int'(flags_in));
        case (op_sel)
            2'd0: chk("R2 result", int'(result_o), e & 255);
            2'd1: chk("R4 result", int'(result_o), e & 255);
            2'd2: chk("R7 result", int'(result_o), e & 255);
            default: chk("R8 result", int'(result_o), e & 255);
        endcase
        chk("R1 write-enables", int'({acc_we_o, mem_we_o}), (e >> 8) & 3);
        chk(m_tag, int'(flags_o), m_flags);
        rst       = r;
        op_sel    = 2'(op);
        acc_in    = 8'(a);
        opnd_in   = 8'(m);
        flags_in  = 8'(fin);
        flag_load = ld;
        e = model(op, a, m, fin);
        if (r) begin
            m_flags = 0; m_tag = "R12 flags after reset";
        end else if (!ld) begin
            m_tag = "R11 flags held without strobe";
        end else begin
            m_flags = (e >> 16) & 255;
            case (op)
                0: m_tag = "R2/R3/R10 XOR flags";
                1: m_tag = "R5/R6/R10 compare flags";
                2: m_tag = "R7/R9 increment flags";
                default: m_tag = "R8/R9 decrement flags";
            endcase
        end
    endtask

    initial begin
        int mv[8];
        int av[4];
        mv = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h0F, 8'h10, 8'h01, 8'h5A};
        av = '{8'h00, 8'h80, 8'h7F, 8'hFF};
        n_chk = 0; n_bad = 0; done = 1'b0;
        rst = 1'b1; op_sel = 2'd0; acc_in = 8'h00; opnd_in = 8'h00;
        flags_in = 8'h00; flag_load = 1'b1;
        m_flags = 0; m_tag = "R12 flags in reset";
        for (int k = 0; k < 3; k++) step(1'b1, 0, 8'hFF, 8'h0F, 8'hFF, 1'b1);
        // Corner sweep: every op over edge operands, carry-in both ways (R9)
        for (int op = 0; op < 4; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 5; j++)
                    step(1'b0, op, (j == 4) ? mv[i] : av[j], mv[i],
                         ((i + j) % 2 == 1) ? 8'h01 : 8'hFE, 1'b1);
        // R11: strobe low after a loaded value must hold it
        step(1'b0, 1, 8'h00, 8'h01, 8'h00, 1'b1);
        for (int k = 0; k < 4; k++) step(1'b0, 0, 8'h00, 8'h00, 8'h00, 1'b0);
        // R12: reset mid-run
        step(1'b1, 1, 8'h10, 8'h20, 8'h00, 1'b1);
        step(1'b0, 3, 8'h00, 8'h80, 8'h01, 1'b0);
        // Random traffic
        for (int k = 0; k < 3000; k++)
            step(1'b0, int'($urandom_range(3)), int'($urandom_range(255)),
                 int'($urandom_range(255)), int'($urandom_range(255)),
                 ($urandom_range(3) != 0));
        step(1'b0, 0, 0, 0, 0, 1'b1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule